// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the 32-bit data address for a register-memory machine with eight 32-bit general-purpose registers. Each cycle it takes an addressing mode, a base register number, an index register number, a 2-bit scale and a displacement. The displacement is either a short 8-bit signed value or a full 32-bit value. The block reads the base and index values through two read ports of a register file that sits outside it. It adds the selected terms and presents the address, with an illegal-operand flag, one clock later.

Register 4 serves as the stack pointer and register 5 as the frame pointer. Some modes forbid them as operands. A forbidden choice raises the flag and forces the address to zero. Decoding of instruction bytes, segment translation and the memory access itself belong to other blocks.

Top module: `agu_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `ea_o` becomes 0 and `illegal_o` becomes 0.
- R2: `mode_i` selects the mode: 0 = register indirect, 1 = based, 2 = scaled index, 3 = scaled index with displacement. `rd_a_addr_o` always equals `base_sel_i` and `rd_b_addr_o` always equals `index_sel_i`, with no clock delay.
- R3: In mode 0 the address is the value of the base register.
- R4: In mode 1 the address is the base register value plus the displacement.
- R5: With `disp_wide_i` = 0, the displacement is `disp_i[7:0]` sign-extended, and `disp_i[31:8]` has no effect. With `disp_wide_i` = 1, all 32 bits of `disp_i` are used.
- R6: In mode 2 the address is base + (index << scale), so scale values 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R7: In mode 3 the address is base + (index << scale) + displacement.
- R8: In modes 0 and 1, a base register of 4 or 5 is illegal.
- R9: In modes 2 and 3, an index register of 4 is illegal. A base of 4 or 5, and an index of 5, are legal.
- R10: Whenever the operand choice is illegal, `illegal_o` is 1 and `ea_o` is 0. Otherwise `illegal_o` is 0.
- R11: All additions wrap modulo 2^32.
- R12: `ea_o` and `illegal_o` reflect the inputs sampled at the previous rising edge, and they hold steady between edges.
- R13: In modes 0 and 1, `index_sel_i` and `scale_i` have no effect. In particular, an index of 4 does not make the operand illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Addressing mode |
| base_sel_i | input | 3 | Base register number |
| index_sel_i | input | 3 | Index register number |
| scale_i | input | 2 | Index shift amount |
| disp_i | input | 32 | Displacement value |
| disp_wide_i | input | 1 | 1 = 32-bit displacement, 0 = 8-bit signed |
| rd_a_addr_o | output | 3 | Register file read port A address (base) |
| rd_a_data_i | input | 32 | Register file read port A data |
| rd_b_addr_o | output | 3 | Register file read port B address (index) |
| rd_b_data_i | input | 32 | Register file read port B data |
| ea_o | output | 32 | Registered effective address |
| illegal_o | output | 1 | Registered illegal-operand flag |

## Verification
Random register contents, modes, scales and displacements of both widths are run against a bench model. These runs separate the four address sums from one another and show whether the shift amount and the sign extension are applied correctly.

Directed cases cover the following:
- Base values near the top of the address space, which expose missing wraparound.
- A short displacement with junk in its upper bits, which shows whether those bits are ignored.
- Each stack and frame pointer placement in each mode, which separates the base restriction from the index restriction.
- Inputs changed between edges, which shows that the outputs move only at a clock edge.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int unsigned XLEN       = 32;
    localparam int unsigned NUM_REGS   = 8;
    localparam int unsigned RIDX_W     = $clog2(NUM_REGS);
    localparam int unsigned SCALE_W    = 2;
    localparam int unsigned SHORT_D_W  = 8;

    localparam logic [RIDX_W-1:0] REG_STACK = RIDX_W'(4);
    localparam logic [RIDX_W-1:0] REG_FRAME = RIDX_W'(5);

    typedef enum logic [1:0] {
        AM_REG_IND    = 2'd0,
        AM_BASED      = 2'd1,
        AM_SCALED     = 2'd2,
        AM_SCALED_DSP = 2'd3
    } agu_mode_e;

    typedef struct packed {
        logic [XLEN-1:0] ea;
        logic            illegal;
    } agu_result_t;

    function automatic logic is_stack_or_frame(input logic [RIDX_W-1:0] r);
        return (r == REG_STACK) || (r == REG_FRAME);
    endfunction

    function automatic logic mode_has_index(input agu_mode_e m);
        return (m == AM_SCALED) || (m == AM_SCALED_DSP);
    endfunction

    function automatic logic mode_has_disp(input agu_mode_e m);
        return (m == AM_BASED) || (m == AM_SCALED_DSP);
    endfunction
endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext #(
    parameter int unsigned OUT_W   = 32,
    parameter int unsigned SHORT_W = 8
) (
    input  logic [OUT_W-1:0] raw_i,
    input  logic             wide_i,
    output logic [OUT_W-1:0] disp_o
);
    localparam int unsigned PAD_W = OUT_W - SHORT_W;

    logic [OUT_W-1:0] short_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign short_ext = {{PAD_W{raw_i[SHORT_W-1]}}, raw_i[SHORT_W-1:0]};
        end else begin : g_nopad
            assign short_ext = raw_i;
        end
    endgenerate

    assign disp_o = wide_i ? raw_i : short_ext;
endmodule

// File: rtl/agu_legal_chk.sv
module agu_legal_chk
    import agu_pkg::*;
(
    input  agu_mode_e         mode_i,
    input  logic [RIDX_W-1:0] base_i,
    input  logic [RIDX_W-1:0] index_i,
    output logic              illegal_o
);
    always_comb begin
        if (mode_has_index(mode_i)) begin
            illegal_o = (index_i == REG_STACK);
        end else begin
            illegal_o = is_stack_or_frame(base_i);
        end
    end
endmodule

// File: rtl/agu_sum.sv
module agu_sum
    import agu_pkg::*;
(
    input  agu_mode_e          mode_i,
    input  logic [XLEN-1:0]    base_val_i,
    input  logic [XLEN-1:0]    index_val_i,
    input  logic [SCALE_W-1:0] scale_i,
    input  logic [XLEN-1:0]    disp_i,
    output logic [XLEN-1:0]    sum_o
);
    logic [XLEN-1:0] idx_term;
    logic [XLEN-1:0] dsp_term;

    always_comb begin
        idx_term = mode_has_index(mode_i) ? (index_val_i << scale_i) : '0;
        dsp_term = mode_has_disp(mode_i) ? disp_i : '0;
        sum_o    = base_val_i + idx_term + dsp_term;
    end
endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode_i,
    input  logic [RIDX_W-1:0]   base_sel_i,
    input  logic [RIDX_W-1:0]   index_sel_i,
    input  logic [SCALE_W-1:0]  scale_i,
    input  logic [XLEN-1:0]     disp_i,
    input  logic                disp_wide_i,
    output logic [RIDX_W-1:0]   rd_a_addr_o,
    input  logic [XLEN-1:0]     rd_a_data_i,
    output logic [RIDX_W-1:0]   rd_b_addr_o,
    input  logic [XLEN-1:0]     rd_b_data_i,
    output logic [XLEN-1:0]     ea_o,
    output logic                illegal_o
);
    agu_mode_e       mode;
    logic [XLEN-1:0] disp_ext;
    logic [XLEN-1:0] raw_sum;
    logic            bad_opnd;
    agu_result_t     next_res;
    agu_result_t     res_q;

    assign mode        = agu_mode_e'(mode_i);
    assign rd_a_addr_o = base_sel_i;
    assign rd_b_addr_o = index_sel_i;

    agu_disp_ext #(
        .OUT_W   (XLEN),
        .SHORT_W (SHORT_D_W)
    ) u_disp (
        .raw_i  (disp_i),
        .wide_i (disp_wide_i),
        .disp_o (disp_ext)
    );

    agu_legal_chk u_legal (
        .mode_i    (mode),
        .base_i    (base_sel_i),
        .index_i   (index_sel_i),
        .illegal_o (bad_opnd)
    );

    agu_sum u_sum (
        .mode_i      (mode),
        .base_val_i  (rd_a_data_i),
        .index_val_i (rd_b_data_i),
        .scale_i     (scale_i),
        .disp_i      (disp_ext),
        .sum_o       (raw_sum)
    );

    always_comb begin
        next_res.illegal = bad_opnd;
        next_res.ea      = bad_opnd ? '0 : raw_sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= next_res;
        end
    end

    assign ea_o      = res_q.ea;
    assign illegal_o = res_q.illegal;
endmodule

// File: rtl/agu_chk.sv
module agu_chk
    import agu_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [1:0]          mode_i,
    input logic [RIDX_W-1:0]   base_sel_i,
    input logic [RIDX_W-1:0]   index_sel_i,
    input logic [SCALE_W-1:0]  scale_i,
    input logic [XLEN-1:0]     disp_i,
    input logic                disp_wide_i,
    input logic [XLEN-1:0]     rd_a_data_i,
    input logic [XLEN-1:0]     rd_b_data_i,
    input logic [XLEN-1:0]     ea_o,
    input logic                illegal_o
);
    logic primed;

    always_ff @(posedge clk) begin
        primed <= !rst;
    end

    AST_ILLEGAL_ZEROES_EA: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (ea_o == '0)) else $error("AST_ILLEGAL_ZEROES_EA"); // R10

    AST_IND_EA: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(mode_i) == 2'd0 && !is_stack_or_frame($past(base_sel_i)))
        |-> (ea_o == $past(rd_a_data_i) && !illegal_o)) else $error("AST_IND_EA"); // R3

    AST_BASE_SP_FP: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(mode_i) < 2'd2 && is_stack_or_frame($past(base_sel_i)))
        |-> illegal_o) else $error("AST_BASE_SP_FP"); // R8

    AST_INDEX_SP: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(mode_i) >= 2'd2)
        |-> (illegal_o == ($past(index_sel_i) == REG_STACK))) else $error("AST_INDEX_SP"); // R9

    AST_SCALED_EA: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(mode_i) == 2'd2 && $past(index_sel_i) != REG_STACK)
        |-> (ea_o == $past(rd_a_data_i) + ($past(rd_b_data_i) << $past(scale_i))))
        else $error("AST_SCALED_EA"); // R6

    AST_SHORT_DISP: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(mode_i) == 2'd1 && !$past(disp_wide_i)
         && !is_stack_or_frame($past(base_sel_i)))
        |-> (ea_o == $past(rd_a_data_i)
             + {{(XLEN-SHORT_D_W){$past(disp_i[SHORT_D_W-1])}}, $past(disp_i[SHORT_D_W-1:0])}))
        else $error("AST_SHORT_DISP"); // R5
endmodule

bind agu_top agu_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_i),
    .base_sel_i  (base_sel_i),
    .index_sel_i (index_sel_i),
    .scale_i     (scale_i),
    .disp_i      (disp_i),
    .disp_wide_i (disp_wide_i),
    .rd_a_data_i (rd_a_data_i),
    .rd_b_data_i (rd_b_data_i),
    .ea_o        (ea_o),
    .illegal_o   (illegal_o)
);

// File: tb/agu_top_tb.sv
`timescale 1ns/1ps
module agu_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode;
    logic [2:0]  bsel, isel;
    logic [1:0]  scale;
    logic [31:0] disp;
    logic        wide;
    logic [2:0]  ra_addr, rb_addr;
    logic [31:0] ra_data, rb_data;
    logic [31:0] ea;
    logic        ill;
    logic [31:0] rf [8];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    assign ra_data = rf[ra_addr];
    assign rb_data = rf[rb_addr];

    agu_top u_dut (
        .clk (clk), .rst (rst), .mode_i (mode), .base_sel_i (bsel),
        .index_sel_i (isel), .scale_i (scale), .disp_i (disp),
        .disp_wide_i (wide), .rd_a_addr_o (ra_addr), .rd_a_data_i (ra_data),
        .rd_b_addr_o (rb_addr), .rd_b_data_i (rb_data),
        .ea_o (ea), .illegal_o (ill)
    );

    function automatic void model(output logic [31:0] e, output logic il);
        logic [31:0] dx;
        logic [31:0] sum;
        dx = wide ? disp : {{24{disp[7]}}, disp[7:0]};
        if (mode < 2) il = (bsel == 3'd4) || (bsel == 3'd5);
        else          il = (isel == 3'd4);
        case (mode)
            2'd0:    sum = rf[bsel];
            2'd1:    sum = rf[bsel] + dx;
            2'd2:    sum = rf[bsel] + (rf[isel] << scale);
            default: sum = rf[bsel] + (rf[isel] << scale) + dx;
        endcase
        e = il ? 32'd0 : sum;
    endfunction

    task automatic check(input string tag, input logic [31:0] e, input logic il);
        checks++;
        if (ea !== e || ill !== il) begin
            fails++;
            $display("FAIL %s: ea=%h ill=%b expected ea=%h ill=%b", tag, ea, ill, e, il);
        end
    endtask

    task automatic apply(input logic [1:0] m, input logic [2:0] b, input logic [2:0] i,
                         input logic [1:0] s, input logic [31:0] d, input logic w,
                         input string tag);
        logic [31:0] e;
        logic        il;
        @(negedge clk);
        mode = m; bsel = b; isel = i; scale = s; disp = d; wide = w;
        model(e, il);
        #0.5;
        checks++;
        if (ra_addr !== b || rb_addr !== i) begin
            fails++;
            $display("FAIL R2: ports a=%0d b=%0d expected a=%0d b=%0d", ra_addr, rb_addr, b, i);
        end
        @(posedge clk);
        #1;
        check(tag, e, il);
    endtask

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] e;
        logic        il;
        void'($urandom(32'd2718));
        for (int k = 0; k < 8; k++) rf[k] = 32'h1000_0000 * k + 32'h0000_0110 * (k + 1);
        rst = 1'b1; mode = 2'd1; bsel = 3'd1; isel = 3'd2; scale = 2'd1;
        disp = 32'h55; wide = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 32'd0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // Directed cases
        apply(2'd0, 3'd3, 3'd0, 2'd0, 32'd0, 1'b0, "R3 indirect");
        apply(2'd0, 3'd4, 3'd0, 2'd0, 32'd0, 1'b0, "R8 indirect sp");
        apply(2'd1, 3'd5, 3'd0, 2'd0, 32'd8, 1'b0, "R8 based fp");
        apply(2'd1, 3'd2, 3'd0, 2'd0, 32'h1234_5678, 1'b1, "R4 based wide");
        apply(2'd1, 3'd2, 3'd0, 2'd0, 32'hABCD_1280, 1'b0, "R5 short neg, upper ignored");
        apply(2'd1, 3'd2, 3'd0, 2'd0, 32'hFFFF_FF7F, 1'b0, "R5 short pos, upper ignored");
        apply(2'd0, 3'd1, 3'd4, 2'd3, 32'd0, 1'b0, "R13 index sp ignored");
        for (int s = 0; s < 4; s++)
            apply(2'd2, 3'd1, 3'd3, s[1:0], 32'd0, 1'b0, "R6 scale");
        apply(2'd2, 3'd4, 3'd5, 2'd2, 32'd0, 1'b0, "R9 base sp, index fp legal");
        apply(2'd3, 3'd5, 3'd4, 2'd1, 32'd4, 1'b1, "R9 index sp illegal");
        apply(2'd3, 3'd6, 3'd7, 2'd3, 32'hFFFF_FFFC, 1'b1, "R7 scaled disp");
        apply(2'd2, 3'd4, 3'd4, 2'd0, 32'd0, 1'b0, "R10 illegal zero ea");
        rf[1] = 32'hFFFF_FFF0;
        apply(2'd1, 3'd1, 3'd0, 2'd0, 32'h20, 1'b1, "R11 wrap based");
        rf[2] = 32'h8000_0001;
        apply(2'd3, 3'd1, 3'd2, 2'd3, 32'h7F, 1'b0, "R11 wrap scaled");

        // R12: outputs hold between edges after inputs change
        apply(2'd0, 3'd3, 3'd0, 2'd0, 32'd0, 1'b0, "R12 setup");
        model(e, il);
        @(negedge clk);
        mode = 2'd1; bsel = 3'd4;
        #1;
        check("R12 hold before edge", e, il);
        @(posedge clk);
        #1;
        check("R12 update after edge", 32'd0, 1'b1);

        // Random
        for (int n = 0; n < 400; n++) begin
            logic [1:0] m;
            string tg;
            for (int k = 0; k < 8; k++) rf[k] = $urandom;
            m = 2'($urandom);
            case (m)
                2'd0:    tg = "R3/R8 rand";
                2'd1:    tg = "R4/R5/R8 rand";
                2'd2:    tg = "R6/R9 rand";
                default: tg = "R7/R9 rand";
            endcase
            apply(m, 3'($urandom), 3'($urandom), 2'($urandom), $urandom, 1'($urandom), tg);
        end

        // R1: reset mid-run clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 reset mid-run", 32'd0, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule